// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power-management state of a processor core. A stop-clock request, a sleep request, a bus-clock-present level and snoop strobes arrive from the system side, and a halt indication arrives from the core. From these the controller steps between a running state, an automatic halt, a granted clock stop, a short snoop window, sleep and deep sleep. While the core is in a stopped state it tells the core whether its clocks may run and whether snoop logic must be woken. It acknowledges cache-flush requests that arrive during halt or grant.

Interrupt-class event lines (SMI, INIT and two local interrupt lines) are gathered while the clock is granted away. Each line keeps at most one pending occurrence. The whole set is handed back as a one-cycle vector when the core runs again. A core reset request takes effect only after it has been held for a programmable number of cycles. During sleep the bus must stay quiet, and any forbidden activity is remembered in a sticky flag.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The state output uses Run=0, Halt=1, Grant=2, Snoop=3, Sleep=4, Deep=5. After the asynchronous reset the state is Run, and the pending vector, the release vector and the illegal-activity flag are all zero.
- R2: In Run, a stop request moves to Grant, and otherwise a halt indication moves to Halt. Sleep requests, snoop strobes and event lines leave Run unchanged.
- R3: In Grant, dropping the stop request returns to Halt if Grant was entered from Halt, and to Run otherwise.
- R4: A snoop start in Halt or Grant enters Snoop. The controller stays in Snoop until a snoop-done strobe, then returns to the state it came from.
- R5: A sleep request is honoured only in Grant and moves to Sleep. In Sleep, releasing it returns to Grant and losing the bus clock enters Deep. Deep is left for Sleep only when the bus clock returns.
- R6: A flush request sampled in Halt or Grant gives a one-cycle flush-done pulse on the next cycle and does not change the state.
- R7: While in Grant, each event line (bit 0 SMI, bit 1 INIT, bit 2 local line 0, bit 3 local line 1) sets its pending bit. Repeated pulses on a line still leave a single bit.
- R8: On every entry to Run other than through a core reset, the release vector shows the pending bits for one cycle, plus any event seen in that last Grant cycle, and the pending vector clears. Pending bits survive a return from Grant to Halt.
- R9: In Halt, any event line wakes the controller to Run, unless a stop request or a snoop start arrives in the same cycle.
- R10: In Sleep or Deep, a snoop strobe, a flush request, an event line or a dropped stop request sets the illegal-activity flag. The flag stays set until a core reset takes effect. A core reset request is not illegal activity.
- R11: A core reset request held for fewer than RST_HOLD consecutive cycles has no effect.
- R12: A core reset held for RST_HOLD cycles clears the pending bits and the illegal flag. From Grant the controller stays in Grant. From any other state, Sleep included, it goes straight to Run without passing through Grant.
- R13: The clock-run output is high only in Run, and the snoop-enable output is high only in Snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Core executed a halt |
| stop_req_i | input | 1 | Stop-clock request level |
| sleep_req_i | input | 1 | Sleep request level |
| bclk_ok_i | input | 1 | Bus clock present |
| snoop_start_i | input | 1 | Snoop detected strobe |
| snoop_done_i | input | 1 | Snoop serviced strobe |
| core_rst_i | input | 1 | Core reset request level |
| flush_req_i | input | 1 | Cache flush request |
| evt_i | input | 4 | Event lines: SMI, INIT, local 0, local 1 |
| state_o | output | 3 | Current state code |
| clk_run_o | output | 1 | Core internal clocks may run |
| snoop_en_o | output | 1 | Snoop logic awake |
| flush_done_o | output | 1 | Flush serviced pulse |
| evt_pend_o | output | 4 | Pending collapsed events |
| evt_rel_o | output | 4 | One-cycle release of pending events |
| bad_activity_o | output | 1 | Sticky illegal activity during sleep |

## Verification
The bench builds the controller with RST_HOLD set to 3. With that value, a reset that is one cycle short and a reset that is exactly long enough can both be tried within a handful of cycles, in Grant and in Sleep. Each of the six states is reached from a fresh reset and hit with each of eleven single-input stimuli. For every pair the bench checks the next state, the illegal flag, the flush pulse and the two clock-domain flags. Directed sequences then cover event collapsing, release after a detour through Halt, and the snoop round trip from Halt.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_GRANT = 3'd2,
    PS_SNOOP = 3'd3,
    PS_SLEEP = 3'd4,
    PS_DEEP  = 3'd5
  } pstate_e;

  // event vector: bit0 SMI, bit1 INIT, bit2 local line 0, bit3 local line 1
  localparam int EVT_N = 4;
endpackage

// File: rtl/pwr_rst_filter.sv
// Qualifies the core reset request: one take pulse per hold of HOLD cycles.
module pwr_rst_filter #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic take_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!req_i)
      cnt_d = '0;
    else if (cnt_q != CW'(HOLD))
      cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign take_o = req_i && (cnt_q == CW'(HOLD - 1));
endmodule

// File: rtl/pwr_fsm.sv
// Power-state sequencer with return bits for stop and snoop detours.
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    halt_i,
  input  logic    stop_i,
  input  logic    sleep_i,
  input  logic    bclk_i,
  input  logic    snp_start_i,
  input  logic    snp_done_i,
  input  logic    wake_i,
  input  logic    take_i,
  output pstate_e st_o,
  output logic    enter_run_o
);
  pstate_e st_q, st_d;
  logic    stop_ret_q, stop_ret_d;   // 1: grant was entered from halt
  logic    snp_ret_q, snp_ret_d;     // 1: snoop was entered from halt
  logic    ret_en;

  always_comb begin
    st_d       = st_q;
    stop_ret_d = stop_ret_q;
    snp_ret_d  = snp_ret_q;
    if (take_i) begin
      st_d       = (st_q == PS_GRANT) ? PS_GRANT : PS_RUN;
      stop_ret_d = 1'b0;
      snp_ret_d  = 1'b0;
    end else begin
      unique case (st_q)
        PS_RUN: begin
          if (stop_i) begin
            st_d       = PS_GRANT;
            stop_ret_d = 1'b0;
          end else if (halt_i) begin
            st_d = PS_HALT;
          end
        end
        PS_HALT: begin
          if (stop_i) begin
            st_d       = PS_GRANT;
            stop_ret_d = 1'b1;
          end else if (snp_start_i) begin
            st_d      = PS_SNOOP;
            snp_ret_d = 1'b1;
          end else if (wake_i) begin
            st_d = PS_RUN;
          end
        end
        PS_GRANT: begin
          if (snp_start_i) begin
            st_d      = PS_SNOOP;
            snp_ret_d = 1'b0;
          end else if (sleep_i) begin
            st_d = PS_SLEEP;
          end else if (!stop_i) begin
            st_d = stop_ret_q ? PS_HALT : PS_RUN;
          end
        end
        PS_SNOOP: begin
          if (snp_done_i)
            st_d = snp_ret_q ? PS_HALT : PS_GRANT;
        end
        PS_SLEEP: begin
          if (!sleep_i)
            st_d = PS_GRANT;
          else if (!bclk_i)
            st_d = PS_DEEP;
        end
        PS_DEEP: begin
          if (bclk_i)
            st_d = PS_SLEEP;
        end
        default: st_d = PS_RUN;
      endcase
    end
  end

  assign ret_en = (stop_ret_d != stop_ret_q) || (snp_ret_d != snp_ret_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      st_q <= PS_RUN;
    else
      st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_ret_q <= 1'b0;
      snp_ret_q  <= 1'b0;
    end else if (ret_en) begin
      stop_ret_q <= stop_ret_d;
      snp_ret_q  <= snp_ret_d;
    end
  end

  assign st_o        = st_q;
  assign enter_run_o = (st_d == PS_RUN) && (st_q != PS_RUN) && !take_i;
endmodule

// File: rtl/pwr_evt_latch.sv
// Collapses events into one pending bit per line and releases them once.
module pwr_evt_latch #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         latch_en_i,
  input  logic         release_i,
  input  logic         clear_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] rel_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] rel_q, rel_d;
  logic [N-1:0] evt_gated;

  assign evt_gated = latch_en_i ? evt_i : '0;

  always_comb begin
    pend_d = pend_q;
    rel_d  = '0;
    if (clear_i) begin
      pend_d = '0;
    end else if (release_i) begin
      rel_d  = pend_q | evt_gated;
      pend_d = '0;
    end else begin
      pend_d = pend_q | evt_gated;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rel_q  <= '0;
    end else begin
      pend_q <= pend_d;
      rel_q  <= rel_d;
    end
  end

  assign pend_o = pend_q;
  assign rel_o  = rel_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             stop_req_i,
  input  logic             sleep_req_i,
  input  logic             bclk_ok_i,
  input  logic             snoop_start_i,
  input  logic             snoop_done_i,
  input  logic             core_rst_i,
  input  logic             flush_req_i,
  input  logic [EVT_N-1:0] evt_i,
  output logic [2:0]       state_o,
  output logic             clk_run_o,
  output logic             snoop_en_o,
  output logic             flush_done_o,
  output logic [EVT_N-1:0] evt_pend_o,
  output logic [EVT_N-1:0] evt_rel_o,
  output logic             bad_activity_o
);
  pstate_e st;
  logic    take;
  logic    enter_run;
  logic    in_sleep;
  logic    activity;
  logic    flush_q, flush_d;
  logic    bad_q, bad_d;

  pwr_rst_filter #(.HOLD(RST_HOLD)) u_rst_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (core_rst_i),
    .take_o (take)
  );

  pwr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .stop_i      (stop_req_i),
    .sleep_i     (sleep_req_i),
    .bclk_i      (bclk_ok_i),
    .snp_start_i (snoop_start_i),
    .snp_done_i  (snoop_done_i),
    .wake_i      (|evt_i),
    .take_i      (take),
    .st_o        (st),
    .enter_run_o (enter_run)
  );

  pwr_evt_latch #(.N(EVT_N)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .latch_en_i (st == PS_GRANT),
    .release_i  (enter_run),
    .clear_i    (take),
    .pend_o     (evt_pend_o),
    .rel_o      (evt_rel_o)
  );

  assign in_sleep = (st == PS_SLEEP) || (st == PS_DEEP);
  assign activity = snoop_start_i || snoop_done_i || flush_req_i ||
                    (|evt_i) || !stop_req_i;

  always_comb begin
    flush_d = flush_req_i && ((st == PS_HALT) || (st == PS_GRANT));
    bad_d   = bad_q;
    if (take)
      bad_d = 1'b0;
    else if (in_sleep && activity)
      bad_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      flush_q <= flush_d;
      bad_q   <= bad_d;
    end
  end

  assign state_o        = st;
  assign clk_run_o      = (st == PS_RUN);
  assign snoop_en_o     = (st == PS_SNOOP);
  assign flush_done_o   = flush_q;
  assign bad_activity_o = bad_q;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_rst_i,
  input logic       snoop_done_i,
  input logic [2:0] state_o,
  input logic       flush_done_o,
  input logic [3:0] evt_pend_o,
  input logic [3:0] evt_rel_o,
  input logic       bad_activity_o
);
  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);

  a_r4_snoop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_SNOOP && !snoop_done_i && !core_rst_i) |=> state_o == PS_SNOOP);

  a_r5_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != PS_SLEEP && state_o != PS_GRANT && state_o != PS_DEEP)
      |=> state_o != PS_SLEEP);

  a_r6_flush_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> ($past(state_o) == PS_HALT || $past(state_o) == PS_GRANT));

  a_r7_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_GRANT && !core_rst_i)
      |=> (state_o == PS_RUN || (evt_pend_o & $past(evt_pend_o)) == $past(evt_pend_o)));

  a_r8_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_rel_o) |-> (state_o == PS_RUN && evt_pend_o == 4'd0));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_activity_o && !core_rst_i) |=> bad_activity_o);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_rst_i     (core_rst_i),
  .snoop_done_i   (snoop_done_i),
  .state_o        (state_o),
  .flush_done_o   (flush_done_o),
  .evt_pend_o     (evt_pend_o),
  .evt_rel_o      (evt_rel_o),
  .bad_activity_o (bad_activity_o)
);

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt, stp, slp, bclk, snps, snpd, crst, fl;
  logic [3:0] evt;
  logic [2:0] state;
  logic       clk_run, snoop_en, flush_done, bad;
  logic [3:0] pend, rel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl #(.RST_HOLD(3)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .halt_i (halt), .stop_req_i (stp),
    .sleep_req_i (slp), .bclk_ok_i (bclk), .snoop_start_i (snps),
    .snoop_done_i (snpd), .core_rst_i (crst), .flush_req_i (fl),
    .evt_i (evt), .state_o (state), .clk_run_o (clk_run),
    .snoop_en_o (snoop_en), .flush_done_o (flush_done),
    .evt_pend_o (pend), .evt_rel_o (rel), .bad_activity_o (bad)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hw_reset();
    halt = 0; stp = 0; slp = 0; bclk = 1; snps = 0; snpd = 0;
    crst = 0; fl = 0; evt = 4'd0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  // reach a state from a fresh reset; levels stay held afterwards
  task automatic goto(int s);
    hw_reset();
    case (s)
      1: begin halt = 1; tick(); halt = 0; end
      2: begin stp = 1; tick(); end
      3: begin stp = 1; tick(); snps = 1; tick(); snps = 0; end
      4: begin stp = 1; tick(); slp = 1; tick(); end
      5: begin stp = 1; tick(); slp = 1; tick(); bclk = 0; tick(); end
      default: ;
    endcase
  endtask

  function automatic int exp_st(int s, int k);
    case (s)
      0: return (k == 9) ? 2 : (k == 10) ? 1 : 0;
      1: return (k == 9) ? 2 : (k == 3) ? 3 : (k == 6) ? 0 : 1;
      2: return (k == 1) ? 0 : (k == 2) ? 4 : (k == 3) ? 3 : 2;
      3: return (k == 4) ? 2 : 3;
      4: return (k == 7) ? 2 : (k == 8) ? 5 : 4;
      5: return (k == 8) ? 4 : 5;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 / R13 reset state
    hw_reset();
    check("R1 state", state, 0);
    check("R1 pend", pend, 0);
    check("R1 rel", rel, 0);
    check("R1 bad", bad, 0);
    check("R13 clk_run", clk_run, 1);
    check("R13 snoop_en", snoop_en, 0);

    // sweep: every state against every single stimulus
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 11; k++) begin
        int e;
        goto(s);
        case (k)
          1: stp = 0;
          2: slp = 1;
          3: snps = 1;
          4: snpd = 1;
          5: fl = 1;
          6: evt = 4'b0001;
          7: slp = 0;
          8: bclk = ~bclk;
          9: stp = 1;
          10: halt = 1;
          default: ;
        endcase
        tick();
        e = exp_st(s, k);
        check($sformatf("R2 R3 R4 R5 R9 s=%0d k=%0d", s, k), state, e);
        check($sformatf("R10 s=%0d k=%0d", s, k), bad,
              (s >= 4 && (k == 1 || k == 3 || k == 4 || k == 5 || k == 6)) ? 1 : 0);
        check($sformatf("R6 s=%0d k=%0d", s, k), flush_done,
              (k == 5 && (s == 1 || s == 2)) ? 1 : 0);
        check($sformatf("R13 run s=%0d k=%0d", s, k), clk_run, (e == 0) ? 1 : 0);
        check($sformatf("R13 snp s=%0d k=%0d", s, k), snoop_en, (e == 3) ? 1 : 0);
        snps = 0; snpd = 0; fl = 0; evt = 4'd0; halt = 0;
      end
    end

    // R7 R8 R3: collapse in Grant entered from Halt, keep across Halt, wake
    hw_reset();
    halt = 1; tick(); halt = 0;
    stp = 1; tick();
    check("R3 grant", state, 2);
    evt = 4'b0001; tick(); evt = 4'd0; tick();
    evt = 4'b0001; tick();
    evt = 4'b1000; tick(); evt = 4'd0;
    check("R7 collapse", pend, 4'b1001);
    stp = 0; tick();
    check("R3 back to halt", state, 1);
    check("R8 kept in halt", pend, 4'b1001);
    check("R8 no release", rel, 0);
    evt = 4'b0010; tick(); evt = 4'd0;
    check("R9 wake", state, 0);
    check("R8 release", rel, 4'b1001);
    check("R8 pend cleared", pend, 0);
    tick();
    check("R8 one cycle", rel, 0);

    // R8: event in the last Grant cycle joins the release
    goto(2);
    evt = 4'b0100; stp = 0; tick(); evt = 4'd0;
    check("R8 same cycle state", state, 0);
    check("R8 same cycle rel", rel, 4'b0100);

    // R4: snoop from Halt waits, returns to Halt
    goto(1);
    snps = 1; tick(); snps = 0;
    check("R4 enter", state, 3);
    tick(); tick();
    check("R4 wait", state, 3);
    snpd = 1; tick(); snpd = 0;
    check("R4 return halt", state, 1);

    // R11 R12: reset in Grant
    goto(2);
    evt = 4'b0001; tick(); evt = 4'd0;
    crst = 1; tick(); tick(); crst = 0; tick();
    check("R11 short reset pend", pend, 4'b0001);
    check("R11 short reset state", state, 2);
    crst = 1; tick(); tick(); tick();
    check("R12 grant stays", state, 2);
    check("R12 pend cleared", pend, 0);
    crst = 0; stp = 0; tick();
    check("R12 then run", state, 0);
    check("R12 no release", rel, 0);

    // R12: reset in Sleep goes straight to Run
    goto(4);
    crst = 1; tick();
    check("R12 sleep hold1", state, 4);
    tick();
    check("R12 sleep hold2", state, 4);
    tick();
    check("R12 sleep direct", state, 0);
    check("R10 reset not activity", bad, 0);
    crst = 0; stp = 0; slp = 0; tick();
    check("R12 run after", state, 0);

    // R10: sticky flag, cleared only by reset
    goto(4);
    fl = 1; tick(); fl = 0;
    check("R10 set", bad, 1);
    slp = 0; tick();
    check("R5 wake grant", state, 2);
    check("R10 sticky grant", bad, 1);
    stp = 0; tick();
    check("R10 sticky run", bad, 1);
    crst = 1; tick(); tick(); tick(); crst = 0;
    check("R10 cleared by reset", bad, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule